// File: doc/BRIEF.md
# PLL rate-change sequencer

This block changes the divider settings of an external PLL without letting a glitch reach the clocked logic. A start pulse brings in a new parameter set: feedback divider, two post dividers, reference divider, fractional-mode disable and a 24-bit fraction. The sequencer first reads the PLL's current settings and its output-mux selection through a simple register port. If the mux is on the PLL, the output is parked on the slow reference clock. The block then writes both divider registers and does a read-modify-write of the fraction register. It polls the lock flag, and at the end it puts the mux back.

If the PLL does not lock within a bounded number of polls, the settings captured at the start are written again, one time only, and the operation ends with an error. In sync mode the block compares the target against the settings already in the PLL. When all six fields match it writes nothing. Sync mode is used to realign parameters at boot when the frequency is right but the settings that produce it are not the preferred ones.

For reference, the PLL's output rate is ref·fbdiv/refdiv, plus ref·frac/(refdiv·2^24) when fractional mode is on, all divided by postdiv1·postdiv2.

Top module: `pll_reprog_seq`

## Requirements
- R1: `busy_o` rises in the cycle after `start_i` is sampled in idle. It stays high through the single cycle in which `done_o` pulses and is low in the next cycle. At the end of reset, `busy_o`, `done_o`, `reg_we_o` and `reg_re_o` are low.
- R2: Mux register at address 3, selection in bits [1:0]: 0 is the slow reference, 1 is the PLL output, 2 is the 32 kHz clock. Before any divider write, and only when the selection read at the start is 1, the block writes 0x0003_0000, which selects slow.
- R3: The register writes occur in this order: address 0, then address 1, then address 2.
  - Address 0 is 0x7FFF in [31:16], postdiv1 in [14:12] and fbdiv in [11:0].
  - Address 1 is 0x11FF in [31:16], dsmpd in [12], postdiv2 in [8:6] and refdiv in [5:0].
  - Address 2 is written without a mask: bits [31:24] as read, then frac in [23:0].
- R4: The fraction write keeps bits [31:24] of the value read back from address 2 during the same operation.
- R5: After programming, bit 10 of address 1 is polled. The first poll that reads 1 ends the attempt. At most LOCK_POLLS polls are made per attempt.
- R6: If an attempt exhausts its polls, the settings read at the start are programmed again in the same R3 order, and `err_o` is 1 when `done_o` pulses. Otherwise `err_o` is 0 at `done_o`.
- R7: If the rollback attempt also times out, the operation ends with `err_o` at 1 and no third programming pass.
- R8: The write of 0x0003_0001 to address 3, which restores the PLL selection, is the last write of the operation. It happens only when R2 bypassed the mux, and it happens whether or not the operation ended in an error.
- R9: With `sync_i` high at start, if all six fields read back equal the target, no register is written and `done_o` pulses 5 cycles after the start edge. If any field differs, the full sequence runs.
- R10: `start_i` while `busy_o` is high is ignored. The operation in flight writes only its own values.
- R11: `done_o` is due 9 + 2r + 2k1 cycles after the start edge, where r is 1 if bypassed and 0 otherwise, and k1 is the number of polls in the first attempt. A rollback adds 4 + 2k2 cycles, where k2 is the number of polls in the rollback attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| sync_i | input | 1 | Skip the rewrite when the current settings equal the target |
| fbdiv_i | input | 12 | Target feedback divider |
| postdiv1_i | input | 3 | Target first post divider |
| refdiv_i | input | 6 | Target reference divider |
| postdiv2_i | input | 3 | Target second post divider |
| dsmpd_i | input | 1 | Target fractional-mode disable |
| frac_i | input | 24 | Target fraction |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Lock timeout seen, valid with done_o |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe, data returned next cycle |
| reg_addr_o | output | 2 | Register address |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, one cycle after reg_re_o |

## Verification
The register bank model returns read data one cycle after the strobe. This puts the completion pulse exactly 9 + 2r + 2k1 cycles after the start edge, with 4 + 2k2 more cycles for a rollback, or 5 cycles for a skipped sync. The bench counts falling edges from the start and checks that `done_o` first appears on the predicted one. Every write strobe seen on a falling edge is compared against the next entry of a queue predicted from the settings held in the bank model. A write that was not predicted fails at once, and a prediction left in the queue after `done_o` fails as well.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int FB_W     = 12;
  localparam int PD_W     = 3;
  localparam int REF_W    = 6;
  localparam int FRAC_W   = 24;
  localparam int WORD_W   = 32;
  localparam int MASK_LSB = 16;
  localparam int PD1_LSB  = 12;
  localparam int PD2_LSB  = 6;
  localparam int DSM_BIT  = 12;
  localparam int LOCK_BIT = 10;

  localparam logic [1:0] A_CON0 = 2'd0;
  localparam logic [1:0] A_CON1 = 2'd1;
  localparam logic [1:0] A_CON2 = 2'd2;
  localparam logic [1:0] A_MODE = 2'd3;

  localparam logic [1:0] MODE_SLOW = 2'd0;
  localparam logic [1:0] MODE_NORM = 2'd1;

  typedef struct packed {
    logic [FB_W-1:0]   fbdiv;
    logic [PD_W-1:0]   pd1;
    logic [REF_W-1:0]  refdiv;
    logic [PD_W-1:0]   pd2;
    logic              dsmpd;
    logic [FRAC_W-1:0] frac;
  } pll_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RDM, S_CMP, S_BYP, S_WR0,
    S_WR1, S_FRD, S_FWR, S_POLL, S_PCHK, S_RST, S_DONE
  } seq_state_e;
endpackage

// File: rtl/pll_seq_fmt.sv
module pll_seq_fmt
  import pll_seq_pkg::*;
(
  input  pll_cfg_t                  cfg_i,
  input  logic [WORD_W-FRAC_W-1:0]  hi_i,
  output logic [WORD_W-1:0]         con0_o,
  output logic [WORD_W-1:0]         con1_o,
  output logic [WORD_W-1:0]         con2_o
);
  localparam logic [15:0] MASK0 = 16'((32'd1 << (PD1_LSB + PD_W)) - 1);
  localparam logic [15:0] MASK1 = 16'(((32'd1 << REF_W) - 1)
                                    | (((32'd1 << PD_W) - 1) << PD2_LSB)
                                    | (32'd1 << DSM_BIT));

  always_comb begin
    con0_o = '0;
    con0_o[MASK_LSB +: 16]   = MASK0;
    con0_o[FB_W-1:0]         = cfg_i.fbdiv;
    con0_o[PD1_LSB +: PD_W]  = cfg_i.pd1;

    con1_o = '0;
    con1_o[MASK_LSB +: 16]   = MASK1;
    con1_o[REF_W-1:0]        = cfg_i.refdiv;
    con1_o[PD2_LSB +: PD_W]  = cfg_i.pd2;
    con1_o[DSM_BIT]          = cfg_i.dsmpd;

    con2_o = {hi_i, cfg_i.frac};
  end
endmodule

// File: rtl/pll_seq_lock_timer.sv
module pll_seq_lock_timer #(
  parameter int unsigned LOCK_POLLS = 24000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(LOCK_POLLS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LOCK_POLLS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= CNT_INIT;
    else if (dec_i)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_INIT);
  p_dec_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q > CNT_W'(1)));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned LOCK_POLLS = 24000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_i,
  input  logic [FB_W-1:0]   fbdiv_i,
  input  logic [PD_W-1:0]   postdiv1_i,
  input  logic [REF_W-1:0]  refdiv_i,
  input  logic [PD_W-1:0]   postdiv2_i,
  input  logic              dsmpd_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [1:0]        reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i
);
  localparam logic [15:0] MODE_MASK = 16'h0003;

  seq_state_e  state_q, state_d;
  pll_cfg_t    new_q, old_q, cfg_in;
  logic        sync_q, remux_q, rolled_q, err_q;
  logic        lock, last, pchk;
  logic [WORD_W-1:0] con0, con1, con2;

  always_comb begin
    cfg_in.fbdiv  = fbdiv_i;
    cfg_in.pd1    = postdiv1_i;
    cfg_in.refdiv = refdiv_i;
    cfg_in.pd2    = postdiv2_i;
    cfg_in.dsmpd  = dsmpd_i;
    cfg_in.frac   = frac_i;
  end

  pll_seq_fmt u_fmt (
    .cfg_i  (new_q),
    .hi_i   (reg_rdata_i[WORD_W-1:FRAC_W]),
    .con0_o (con0),
    .con1_o (con1),
    .con2_o (con2)
  );

  assign lock = reg_rdata_i[LOCK_BIT];
  assign pchk = (state_q == S_PCHK);

  pll_seq_lock_timer #(.LOCK_POLLS(LOCK_POLLS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_WR0),
    .dec_i  (pchk && !lock && !last),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_RD0;
      S_RD0:  state_d = S_RD1;
      S_RD1:  state_d = S_RD2;
      S_RD2:  state_d = S_RDM;
      S_RDM:  state_d = S_CMP;
      S_CMP: begin
        if (sync_q && (old_q == new_q))          state_d = S_DONE;
        else if (reg_rdata_i[1:0] == MODE_NORM)  state_d = S_BYP;
        else                                     state_d = S_WR0;
      end
      S_BYP:  state_d = S_WR0;
      S_WR0:  state_d = S_WR1;
      S_WR1:  state_d = S_FRD;
      S_FRD:  state_d = S_FWR;
      S_FWR:  state_d = S_POLL;
      S_POLL: state_d = S_PCHK;
      S_PCHK: begin
        if (lock || (last && rolled_q)) state_d = remux_q ? S_RST : S_DONE;
        else if (last)                  state_d = S_WR0;
        else                            state_d = S_POLL;
      end
      S_RST:  state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      new_q    <= '0;
      old_q    <= '0;
      sync_q   <= 1'b0;
      remux_q  <= 1'b0;
      rolled_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: if (start_i) begin
          new_q    <= cfg_in;
          sync_q   <= sync_i;
          err_q    <= 1'b0;
          rolled_q <= 1'b0;
          remux_q  <= 1'b0;
        end
        S_RD1: begin
          old_q.fbdiv <= reg_rdata_i[FB_W-1:0];
          old_q.pd1   <= reg_rdata_i[PD1_LSB +: PD_W];
        end
        S_RD2: begin
          old_q.refdiv <= reg_rdata_i[REF_W-1:0];
          old_q.pd2    <= reg_rdata_i[PD2_LSB +: PD_W];
          old_q.dsmpd  <= reg_rdata_i[DSM_BIT];
        end
        S_RDM:  old_q.frac <= reg_rdata_i[FRAC_W-1:0];
        S_CMP:  remux_q <= (reg_rdata_i[1:0] == MODE_NORM);
        S_PCHK: if (!lock && last) begin
          err_q <= 1'b1;
          if (!rolled_q) begin
            rolled_q <= 1'b1;
            new_q    <= old_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_we_o    = 1'b0;
    reg_re_o    = 1'b0;
    reg_addr_o  = A_CON0;
    reg_wdata_o = '0;
    case (state_q)
      S_RD0:  begin reg_re_o = 1'b1; reg_addr_o = A_CON0; end
      S_RD1:  begin reg_re_o = 1'b1; reg_addr_o = A_CON1; end
      S_RD2:  begin reg_re_o = 1'b1; reg_addr_o = A_CON2; end
      S_RDM:  begin reg_re_o = 1'b1; reg_addr_o = A_MODE; end
      S_BYP:  begin reg_we_o = 1'b1; reg_addr_o = A_MODE;
                    reg_wdata_o = {MODE_MASK, 14'd0, MODE_SLOW}; end
      S_WR0:  begin reg_we_o = 1'b1; reg_addr_o = A_CON0; reg_wdata_o = con0; end
      S_WR1:  begin reg_we_o = 1'b1; reg_addr_o = A_CON1; reg_wdata_o = con1; end
      S_FRD:  begin reg_re_o = 1'b1; reg_addr_o = A_CON2; end
      S_FWR:  begin reg_we_o = 1'b1; reg_addr_o = A_CON2; reg_wdata_o = con2; end
      S_POLL: begin reg_re_o = 1'b1; reg_addr_o = A_CON1; end
      S_RST:  begin reg_we_o = 1'b1; reg_addr_o = A_MODE;
                    reg_wdata_o = {MODE_MASK, 14'd0, MODE_NORM}; end
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign err_o  = err_q;

  p_done_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_busy_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !pchk) |=> $stable(new_q));
  p_restore_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == A_MODE && reg_wdata_o[1:0] == MODE_NORM) |-> remux_q);
  p_no_third_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pchk && !lock && last && rolled_q) |=> (state_q != S_WR0));
  p_skip_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMP && sync_q && old_q == new_q) |=> (!reg_we_o && done_o));
endmodule

// File: tb/pll_reprog_seq_tb_top.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb_top;
  import pll_seq_pkg::*;
  localparam int POLLS = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, sync_i = 1'b0;
  logic [11:0] fbdiv_i = '0;
  logic [2:0]  postdiv1_i = '0, postdiv2_i = '0;
  logic [5:0]  refdiv_i = '0;
  logic        dsmpd_i = 1'b0;
  logic [23:0] frac_i = '0;
  logic busy_o, done_o, err_o, reg_we_o, reg_re_o;
  logic [1:0]  reg_addr_o;
  logic [31:0] reg_wdata_o, reg_rdata_i;

  always #2.5 clk_i = ~clk_i;

  pll_reprog_seq #(.LOCK_POLLS(POLLS)) dut_i (.*);

  int checks = 0, errors = 0;
  logic [31:0] bank [4];
  int lock_at [4];
  int poll_n = 0, attempt = 0;
  logic [33:0] exp_q [$];

  // register bank model, one-cycle read latency, upper-half write masks
  always @(posedge clk_i) begin
    logic [31:0] v, m;
    if (reg_re_o) begin
      v = bank[reg_addr_o];
      if (reg_addr_o == 2'd1) begin
        poll_n++;
        v[10] = (lock_at[attempt] != 0) && (poll_n >= lock_at[attempt]);
      end
      reg_rdata_i <= v;
    end
    if (reg_we_o) begin
      if (reg_addr_o == 2'd2) bank[2] = reg_wdata_o;
      else begin
        m = {16'h0, reg_wdata_o[31:16]};
        bank[reg_addr_o] = (bank[reg_addr_o] & ~m) | (reg_wdata_o & m);
      end
      if (reg_addr_o == 2'd1) begin
        if (attempt < 3) attempt++;
        poll_n = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every write is compared against the predicted queue
  always @(negedge clk_i) begin
    if (rst_ni && reg_we_o) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected write", {reg_addr_o, reg_wdata_o}, 0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({reg_addr_o, reg_wdata_o} == e, "R3 write sequence", {reg_addr_o, reg_wdata_o}, e);
      end
    end
  end

  function automatic logic [31:0] w0(pll_cfg_t c); return {16'h7FFF, 1'b0, c.pd1, c.fbdiv}; endfunction
  function automatic logic [31:0] w1(pll_cfg_t c);
    return {16'h11FF, 3'b0, c.dsmpd, 3'b0, c.pd2, c.refdiv};
  endfunction
  function automatic pll_cfg_t mk(int fb, int p1, int rf, int p2, bit d, int fr);
    pll_cfg_t c;
    c.fbdiv = 12'(fb); c.pd1 = 3'(p1); c.refdiv = 6'(rf);
    c.pd2 = 3'(p2); c.dsmpd = d; c.frac = 24'(fr);
    return c;
  endfunction

  task automatic preload(input pll_cfg_t c, input logic [1:0] mode, input logic [7:0] hi);
    bank[0] = {17'b0, c.pd1, c.fbdiv};
    bank[1] = {19'b0, c.dsmpd, 3'b0, c.pd2, c.refdiv};
    bank[2] = {hi, c.frac};
    bank[3] = {30'b0, mode};
  endtask

  task automatic run_op(input pll_cfg_t c, input bit sync, input int l1, input int l2,
                        input bit poke, input string tag);
    pll_cfg_t old;
    bit r, skip, t1, t2;
    int k1, k2, j, cyc;
    logic [7:0] hi;
    old.fbdiv = bank[0][11:0]; old.pd1 = bank[0][14:12];
    old.refdiv = bank[1][5:0]; old.pd2 = bank[1][8:6]; old.dsmpd = bank[1][12];
    old.frac = bank[2][23:0];
    hi = bank[2][31:24];
    r = (bank[3][1:0] == 2'd1);
    skip = sync && (old == c);
    t1 = (l1 == 0) || (l1 > POLLS);
    t2 = (l2 == 0) || (l2 > POLLS);
    k1 = t1 ? POLLS : l1;
    k2 = t2 ? POLLS : l2;
    lock_at[0] = 0; lock_at[1] = l1; lock_at[2] = l2; lock_at[3] = 0;
    attempt = 0; poll_n = 0;
    exp_q.delete();
    if (!skip) begin
      if (r) exp_q.push_back({2'd3, 32'h0003_0000});
      exp_q.push_back({2'd0, w0(c)});
      exp_q.push_back({2'd1, w1(c)});
      exp_q.push_back({2'd2, hi, c.frac});
      if (t1) begin
        exp_q.push_back({2'd0, w0(old)});
        exp_q.push_back({2'd1, w1(old)});
        exp_q.push_back({2'd2, hi, old.frac});
      end
      if (r) exp_q.push_back({2'd3, 32'h0003_0001});
    end
    j = skip ? 5 : 9 + 2*int'(r) + 2*k1 + (t1 ? 4 + 2*k2 : 0);
    fbdiv_i = c.fbdiv; postdiv1_i = c.pd1; refdiv_i = c.refdiv;
    postdiv2_i = c.pd2; dsmpd_i = c.dsmpd; frac_i = c.frac;
    sync_i = sync; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      chk(busy_o == 1'b1, {tag, " R1 busy"}, busy_o, 1);
      if (poke && cyc == 3) begin
        start_i = 1'b1; fbdiv_i = ~c.fbdiv; frac_i = ~c.frac; sync_i = 1'b0;
      end else start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc == j + 1, {tag, " R11 done latency"}, cyc, j + 1);
    chk(err_o == t1, {tag, " R6 err at done"}, err_o, t1);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && done_o == 1'b0, {tag, " R1 idle after done"}, busy_o, 0);
    chk(exp_q.size() == 0, {tag, " R3 writes missing"}, exp_q.size(), 0);
    chk(bank[2][31:24] == hi, {tag, " R4 fraction upper bits"}, bank[2][31:24], hi);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pll_cfg_t a, b;
    a = mk(12'h064, 3, 1, 1, 1'b1, 0);
    b = mk(12'h0C6, 2, 2, 1, 1'b0, 24'h123456);
    preload(a, 2'd1, 8'hA5);
    reg_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !reg_we_o && !reg_re_o, "R1 reset state",
        {busy_o, done_o, reg_we_o, reg_re_o}, 0);

    run_op(b, 0, 3, 0, 0, "T1 normal R2 R5 R8");
    preload(a, 2'd0, 8'h3C);
    run_op(b, 0, 1, 0, 0, "T2 slow no bypass R2");
    preload(a, 2'd2, 8'h00);
    run_op(b, 0, 2, 0, 0, "T3 32k no bypass R2");
    preload(a, 2'd1, 8'h5A);
    run_op(b, 0, 0, 2, 0, "T4 rollback R6");
    preload(a, 2'd1, 8'hFF);
    run_op(b, 0, 0, 0, 0, "T5 double timeout R7");
    preload(b, 2'd1, 8'h11);
    run_op(b, 1, 1, 0, 0, "T6 sync match R9");
    preload(mk(12'h0C6, 2, 2, 1, 1'b0, 24'h123457), 2'd1, 8'h22);
    run_op(b, 1, 4, 0, 0, "T7 sync frac differs R9");
    preload(mk(12'h0C6, 2, 2, 1, 1'b1, 24'h123456), 2'd0, 8'h33);
    run_op(b, 1, 2, 0, 0, "T8 sync dsmpd differs R9");
    preload(a, 2'd1, 8'h44);
    run_op(b, 0, 5, 0, 1, "T9 start while busy R10");
    chk(bank[0] == {17'b0, b.pd1, b.fbdiv}, "R10 final divider", bank[0], {17'b0, b.pd1, b.fbdiv});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule